// File: doc/BRIEF.md
# Programmable product-term array with term steering

This block is the combinational heart of one logic block in a programmable logic device. A bus of routed inputs is turned into literals: each input appears once as itself and once inverted. An AND plane builds a pool of product terms from those literals. An OR plane then forms one sum for each macrocell, and each sum is the OR of whichever pool terms that macrocell has been given. A single term can feed several macrocells at once. Each macrocell may take anywhere from none of the terms up to a fixed limit.

Two banks of configuration registers select which literals each term uses and which terms each macrocell uses. Both banks are loaded through one address/data write port. The `cfg_sel_i` input picks the bank. A write is refused if it would give a macrocell more terms than the limit, or if its address is outside the chosen bank. A refused write leaves the configuration as it was and raises an error pulse. Neither the data path nor the outputs have any register stage, so a new input value shows up on the outputs in the same cycle.

Top module: `pta_core`

## Requirements
- R1: While reset is asserted and afterwards until a write, every connection and allocation mask is zero, so `pterm_o`, `sum_o` and `cfg_err_o` are all 0.
- R2: Literal column j, for j below N_IN, is input j. Column N_IN+j is input j inverted. Bit c of a term's connection mask joins column c to that term.
- R3: A product term is 1 exactly when it has at least one literal connected and every connected literal is 1. A term with no literals connected is 0, and so is a term connected to both forms of the same input.
- R4: Sum m is the OR of the product terms whose bits are set in macrocell m's allocation mask, where bit k selects term k. An empty mask gives 0.
- R5: Any number of macrocells may select the same product term at the same time, and each of them sees that term.
- R6: An allocation write is accepted when its low N_PT data bits contain between 0 and MAX_PT ones, inclusive of both limits.
- R7: An allocation write with more than MAX_PT ones in its low N_PT data bits is refused: the mask stays as it was, and `cfg_err_o` is 1 for exactly the cycle after the write.
- R8: A write whose address is not below N_PT (AND bank) or not below N_MC (allocation bank) changes nothing and raises `cfg_err_o` for the cycle after the write.
- R9: An accepted write changes the outputs only after the clock edge that captures it. Until that edge, the outputs still follow the old configuration.
- R10: An AND-bank write stores only the low 2*N_IN data bits, and an allocation write stores only the low N_PT bits. Higher data bits have no effect.
- R11: Outputs are combinational in `in_i`: a change on the inputs shows up on `pterm_o` and `sum_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_i | input | N_IN | Routed input bus |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Bank select: 0 = AND-plane connection, 1 = allocation |
| cfg_addr_i | input | ADDR_W | Term index (bank 0) or macrocell index (bank 1) |
| cfg_data_i | input | DATA_W | Mask to write, where DATA_W = max(2*N_IN, N_PT) |
| cfg_err_o | output | 1 | One-cycle pulse after a refused write |
| pterm_o | output | N_PT | Product-term pool |
| sum_o | output | N_MC | Per-macrocell sum terms |

## Verification
The bench builds the block at full size: 36 inputs, 86 terms, 16 macrocells and a limit of 16 terms per macrocell. At this size the data word is wider than the literal field, so the upper bits that an AND-bank write must ignore can actually be driven. The allocation limit can be tested exactly, at 16 and at 17 set bits. Both address banks have addresses that exist in one bank but not the other, such as 16 through 85, so the range check can be tested per bank. Random sparse masks applied over many cycles cover term sharing and the combinational timing of the inputs.

// File: rtl/pta_pkg.sv
package pta_pkg;
  typedef enum logic {
    BANK_AND   = 1'b0,
    BANK_ALLOC = 1'b1
  } cfg_bank_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pta_cfg.sv
module pta_cfg
  import pta_pkg::*;
#(
  parameter int unsigned N_LIT  = 72,
  parameter int unsigned N_PT   = 86,
  parameter int unsigned N_MC   = 16,
  parameter int unsigned MAX_PT = 16,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 86
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic                           sel_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic                           err_o,
  output logic [N_PT-1:0][N_LIT-1:0]     conn_o,
  output logic [N_MC-1:0][N_PT-1:0]      alloc_o
);
  logic [N_PT-1:0][N_LIT-1:0] conn_q;
  logic [N_MC-1:0][N_PT-1:0]  alloc_q;
  logic                       err_q;
  int unsigned                ones;
  logic                       addr_ok, over, accept;

  always_comb begin
    ones = 0;
    for (int i = 0; i < int'(N_PT); i++) ones += 32'(data_i[i]);
  end

  assign addr_ok = (cfg_bank_e'(sel_i) == BANK_ALLOC) ? (int'(addr_i) < int'(N_MC))
                                                      : (int'(addr_i) < int'(N_PT));
  assign over    = (cfg_bank_e'(sel_i) == BANK_ALLOC) && (ones > MAX_PT);
  assign accept  = we_i && addr_ok && !over;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q  <= '0;
      alloc_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= we_i && !accept;
      for (int k = 0; k < int'(N_PT); k++)
        if (accept && !sel_i && addr_i == ADDR_W'(k)) conn_q[k] <= data_i[N_LIT-1:0];
      for (int m = 0; m < int'(N_MC); m++)
        if (accept && sel_i && addr_i == ADDR_W'(m)) alloc_q[m] <= data_i[N_PT-1:0];
    end
  end

  assign conn_o  = conn_q;
  assign alloc_o = alloc_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pta_and_plane.sv
module pta_and_plane #(
  parameter int unsigned N_IN = 36,
  parameter int unsigned N_PT = 86,
  localparam int unsigned N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]              in_i,
  input  logic [N_PT-1:0][N_LIT-1:0]   conn_i,
  output logic [N_PT-1:0]              pt_o
);
  logic [N_LIT-1:0] lit;
  assign lit = {~in_i, in_i};

  for (genvar k = 0; k < N_PT; k++) begin : g_term
    // empty term forced low
    assign pt_o[k] = (|conn_i[k]) & (&(lit | ~conn_i[k]));
  end
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
  parameter int unsigned N_PT = 86,
  parameter int unsigned N_MC = 16
) (
  input  logic [N_PT-1:0]             pt_i,
  input  logic [N_MC-1:0][N_PT-1:0]   alloc_i,
  output logic [N_MC-1:0]             sum_o
);
  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    assign sum_o[m] = |(pt_i & alloc_i[m]);
  end
endmodule

// File: rtl/pta_core.sv
module pta_core
  import pta_pkg::*;
#(
  parameter int unsigned N_IN   = 36,
  parameter int unsigned N_PT   = 86,
  parameter int unsigned N_MC   = 16,
  parameter int unsigned MAX_PT = 16,
  localparam int unsigned N_LIT  = 2 * N_IN,
  localparam int unsigned DATA_W = max_u(N_LIT, N_PT),
  localparam int unsigned ADDR_W = $clog2(max_u(N_PT, N_MC) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   in_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic              cfg_err_o,
  output logic [N_PT-1:0]   pterm_o,
  output logic [N_MC-1:0]   sum_o
);
  logic [N_PT-1:0][N_LIT-1:0] conn;
  logic [N_MC-1:0][N_PT-1:0]  alloc;

  pta_cfg #(
    .N_LIT(N_LIT), .N_PT(N_PT), .N_MC(N_MC), .MAX_PT(MAX_PT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .addr_i  (cfg_addr_i),
    .data_i  (cfg_data_i),
    .err_o   (cfg_err_o),
    .conn_o  (conn),
    .alloc_o (alloc)
  );

  pta_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_i   (in_i),
    .conn_i (conn),
    .pt_o   (pterm_o)
  );

  pta_or_plane #(.N_PT(N_PT), .N_MC(N_MC)) u_or (
    .pt_i    (pterm_o),
    .alloc_i (alloc),
    .sum_o   (sum_o)
  );
endmodule

// File: rtl/pta_core_chk.sv
module pta_core_chk #(
  parameter int unsigned N_IN   = 36,
  parameter int unsigned N_PT   = 86,
  parameter int unsigned N_MC   = 16,
  parameter int unsigned MAX_PT = 16,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 86
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IN-1:0]   in_i,
  input logic              cfg_we_i,
  input logic              cfg_sel_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [DATA_W-1:0] cfg_data_i,
  input logic              cfg_err_o,
  input logic [N_PT-1:0]   pterm_o,
  input logic [N_MC-1:0]   sum_o
);
  // R7
  err_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(cfg_we_i));

  // R7
  over_limit_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i && ($countones(cfg_data_i[N_PT-1:0]) > MAX_PT)) |=> cfg_err_o);

  // R8
  bad_addr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_sel_i && (int'(cfg_addr_i) >= int'(N_PT))) |=> cfg_err_o);

  // R4
  sum_needs_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sum_o) |-> (|pterm_o));

  // R9
  hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_we_i) && $stable(in_i)) |-> ($stable(pterm_o) && $stable(sum_o)));
endmodule

bind pta_core pta_core_chk #(
  .N_IN(N_IN), .N_PT(N_PT), .N_MC(N_MC), .MAX_PT(MAX_PT),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_i       (in_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_sel_i  (cfg_sel_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_data_i (cfg_data_i),
  .cfg_err_o  (cfg_err_o),
  .pterm_o    (pterm_o),
  .sum_o      (sum_o)
);

// File: tb/pta_core_bench.sv
module pta_core_bench;
  localparam int NI = 36, NP = 86, NM = 16, MX = 16;
  localparam int NL = 2 * NI, DW = 86, AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] in_v = '0;
  logic          we = 1'b0, sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          err;
  logic [NP-1:0] pt;
  logic [NM-1:0] sum;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  bit [NL-1:0] m_conn [NP];
  bit [NP-1:0] m_alloc[NM];
  bit          m_err = 1'b0;

  always #2 clk = ~clk;

  pta_core #(.N_IN(NI), .N_PT(NP), .N_MC(NM), .MAX_PT(MX)) u_pta_core (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_addr_i(addr), .cfg_data_i(data), .cfg_err_o(err), .pterm_o(pt), .sum_o(sum)
  );

  function automatic bit [NP-1:0] exp_pt();
    bit [NP-1:0] r = '0;
    for (int k = 0; k < NP; k++) begin
      bit any = 0, all = 1;
      for (int c = 0; c < NL; c++)
        if (m_conn[k][c]) begin
          any = 1;
          if ((c < NI) ? !in_v[c] : in_v[c-NI]) all = 0;
        end
      r[k] = any && all;
    end
    return r;
  endfunction

  function automatic bit [NM-1:0] exp_sum(bit [NP-1:0] p);
    bit [NM-1:0] r = '0;
    for (int m = 0; m < NM; m++)
      for (int k = 0; k < NP; k++)
        if (m_alloc[m][k] && p[k]) r[m] = 1;
    return r;
  endfunction

  task automatic cmp_out(string t);
    bit [NP-1:0] ep = exp_pt();
    bit [NM-1:0] es = exp_sum(ep);
    n_chk += 2;
    if (pt !== ep) begin n_fail++; $display("FAIL %s pterm_o got %h exp %h", t, pt, ep); end
    if (sum !== es) begin n_fail++; $display("FAIL %s sum_o got %h exp %h", t, sum, es); end
  endtask

  task automatic cmp_all();
    cmp_out(tag);
    n_chk++;
    if (err !== m_err) begin n_fail++; $display("FAIL %s cfg_err_o got %b exp %b", tag, err, m_err); end
  endtask

  // check, then drive one cycle of stimulus and advance the model
  task automatic step(bit w, bit s, int a, bit [DW-1:0] d, bit [NI-1:0] iv);
    int ones = 0;
    bit ok;
    @(negedge clk);
    cmp_all();
    in_v = iv; we = w; sel = s; addr = AW'(a); data = d;
    if (w) begin
      #1 cmp_out("R9");  // old configuration still visible before the edge
    end
    for (int i = 0; i < NP; i++) ones += int'(d[i]);
    ok = w && (s ? (a < NM && ones <= MX) : (a < NP));
    if (ok && !s) m_conn[a] = d[NL-1:0];
    if (ok && s)  m_alloc[a] = d[NP-1:0];
    m_err = w && !ok;
  endtask

  task automatic idle(bit [NI-1:0] iv);
    step(0, 0, 0, '0, iv);
  endtask

  function automatic bit [DW-1:0] bits(int lo, int n);
    bit [DW-1:0] r = '0;
    for (int i = lo; i < lo + n; i++) r[i] = 1;
    return r;
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NP; k++) m_conn[k] = '0;
    for (int m = 0; m < NM; m++) m_alloc[m] = '0;
    repeat (3) @(negedge clk);
    tag = "R1"; cmp_all();  // in reset
    rst_n = 1'b1;
    idle('1); idle('0);

    // R2 R3: term 0 = in0 & ~in1 (columns 0 and NI+1)
    tag = "R2";
    step(1, 0, 0, bits(0, 1) | bits(NI + 1, 1), '0);
    idle(36'h1); idle(36'h3); idle(36'h2); idle(36'h1);
    // R3: term 1 = in0 & ~in0, never true; term 2 = in2
    tag = "R3";
    step(1, 0, 1, bits(0, 1) | bits(NI, 1), 36'h1);
    step(1, 0, 2, bits(2, 1), '0);
    idle('0); idle('1); idle(36'h4); idle(36'h5);

    // R4: mc0 <- term0
    tag = "R4";
    step(1, 1, 0, bits(0, 1), 36'h1);
    idle(36'h1); idle(36'h0);
    // R5: mc5 and mc9 share term0, mc5 also term2
    tag = "R5";
    step(1, 1, 5, bits(0, 1) | bits(2, 1), 36'h1);
    step(1, 1, 9, bits(0, 1), 36'h1);
    idle(36'h1); idle(36'h4); idle(36'h5); idle(36'h0);

    // R6: exactly MX terms, then empty mask
    tag = "R6";
    step(1, 1, 1, bits(0, MX), 36'h1);
    idle(36'h1); idle(36'h4);
    step(1, 1, 2, '0, 36'h1);
    idle(36'h1);
    // R7: MX+1 terms refused, mc1 keeps old mask
    tag = "R7";
    step(1, 1, 1, bits(3, MX + 1), 36'h4);
    idle(36'h4); idle(36'h1); idle(36'h4);

    // R8: out-of-range addresses in both banks
    tag = "R8";
    step(1, 0, NP, '1, '1);
    step(1, 1, NM, bits(0, 1), 36'h1);
    step(1, 1, 40, bits(0, 1), 36'h1);
    idle(36'h1); idle('1);

    // R10: AND write with upper bits set; alloc write with bits above NP irrelevant here (DW==NP)
    tag = "R10";
    step(1, 0, 3, bits(NL, DW - NL) | bits(5, 1), 36'h20);
    idle(36'h20); idle(36'h0);

    // R11 / random sparse traffic
    tag = "R11";
    for (int i = 0; i < 600; i++) begin
      bit [DW-1:0] d;
      bit [NI-1:0] iv = {$urandom, $urandom};
      bit w = ($urandom % 3) == 0;
      bit s = $urandom % 2;
      int a = s ? ($urandom % (NM + 2)) : ($urandom % (NP + 2));
      if (s) d = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
               & (($urandom % 4 == 0) ? '1 : {$urandom, $urandom, $urandom});
      else d = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
             & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      step(w, s, a, d, iv);
    end
    idle('0);
    @(negedge clk); cmp_all();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule